// File: doc/BRIEF.md
# Conformance Test Step Runner

This block steps a device under test through a stored list of test steps and decides whether the device behaved as its state-machine specification requires. Each entry in the list pairs a stimulus valuation, which the block drives onto the device's inputs, with the output valuation the specification expects for that step. The expected value depends on the device state the step starts from as well as on the stimulus. The list is prepared beforehand so that each step starts in the state the previous step left. The first stimulus is chosen so that it keeps the device in its initial state.

The device runs on its own clock and is not aligned to this block. For each step the block therefore does four things in order. It applies the stimulus and then waits a programmable settling interval that covers several device cycles. It then samples the device outputs through a synchronizer and compares them with the expected value. The result of that comparison goes into the verdict logic.

Software loads the list through a write port, sets the settling count and the index of the last step, and pulses start. When the run ends the block raises done. It reports a pass/fail verdict, the number of mismatching steps, and the index, expected value and observed value of the first mismatch. A parameter chooses whether the run stops at the first mismatch or continues to the end.

Top module: `conf_step_exec`

## Requirements
- R1: After reset, dut_in is 0, busy, done, run_pass and fail_seen are 0, and mismatch_count is 0.
- R2: A write with wr_en high stores wr_stim and wr_expect in entry wr_addr. Bit i of every valuation is device signal i, with weight 2^i. Step k of a run drives the stimulus stored in entry k.
- R3: With settling count S captured at start, each step takes exactly S+3 clock cycles. After the edge that accepts start, done is high from edge number N·(S+3) onward, where N is the number of steps executed.
- R4: Once a step's stimulus appears on dut_in, it stays unchanged until that step's compare is finished. The compare uses dut_out after SYNC_STAGES synchronizer flops.
- R5: mismatch_count gives the number of steps in the run whose observed output differed from the stored expected value.
- R6: On the first mismatch of a run, fail_seen is set and fail_step, fail_expect and fail_observed capture that step. Later mismatches do not change these outputs.
- R7: run_pass is 1 only while done is high, the run reached step last_step, and no step mismatched.
- R8: With HALT_ON_FAIL=1, the run ends with done after the first mismatching step, and run_pass is 0. With HALT_ON_FAIL=0, the run always continues to last_step.
- R9: A start pulse that arrives while busy is high is ignored. The run in progress keeps its timing and its results.
- R10: settle_cycles and last_step are captured when start is accepted. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the step list |
| wr_addr | input | AW | Entry being written |
| wr_stim | input | IN_W | Stimulus valuation to store |
| wr_expect | input | OUT_W | Expected output valuation to store |
| last_step | input | AW | Index of the final step of the run |
| settle_cycles | input | SETTLE_W | Settling wait, in clock cycles |
| start | input | 1 | Start pulse |
| dut_in | output | IN_W | Stimulus driven to the device |
| dut_out | input | OUT_W | Device outputs, asynchronous to clk |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| run_pass | output | 1 | Conformance verdict |
| fail_seen | output | 1 | At least one mismatch has occurred in this run |
| fail_step | output | AW | Index of the first mismatching step |
| fail_expect | output | OUT_W | Expected value at the first mismatch |
| fail_observed | output | OUT_W | Observed value at the first mismatch |
| mismatch_count | output | AW+1 | Number of mismatching steps |

## Verification
A new stimulus appears on dut_in one edge after its step begins. That step's compare lands S+2 edges later. done and the verdict outputs change on the edge that closes the last step executed, which is edge N·(S+3) after start is accepted. The bench counts edges from the accepting edge and samples every output at the falling edge. It then checks dut_in against entry (j−1)/(S+3) on every cycle j, and compares the edge at which done rises with N·(S+3) for both the continuing instance and the halting instance. Settling counts are always at least four, which covers the bench device's two-cycle output lag plus the two synchronizer flops. With that margin the only mismatches are the ones the bench injects into the expected values.

// File: rtl/cse_pkg.sv
package cse_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_APPLY,
      PH_SETTLE,
      PH_CHECK,
      PH_DONE
   } phase_t;
endpackage

// File: rtl/cse_step_store.sv
module cse_step_store #(
   parameter int IN_W  = 3,
   parameter int OUT_W = 3,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [IN_W-1:0]  wr_stim,
   input  logic [OUT_W-1:0] wr_exp,
   input  logic [AW-1:0]    rd_addr,
   output logic [IN_W-1:0]  rd_stim,
   output logic [OUT_W-1:0] rd_exp
);
   if (DEPTH != (1 << AW)) begin : g_depth_chk
      $error("cse_step_store: DEPTH must be a power of two");
   end

   logic [IN_W-1:0]  stim_q [DEPTH];
   logic [OUT_W-1:0] exp_q  [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            stim_q[i] <= '0;
            exp_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_addr == AW'(i))) begin
               stim_q[i] <= wr_stim;
               exp_q[i]  <= wr_exp;
            end
         end
      end
   end

   assign rd_stim = stim_q[rd_addr];
   assign rd_exp  = exp_q[rd_addr];
endmodule

// File: rtl/cse_settle_timer.sv
module cse_settle_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   if (W < 1) begin : g_w_chk
      $error("cse_settle_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign expired = (cnt_q == '0);

   // R3
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/cse_obs_sync.sv
module cse_obs_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_stage_chk
      $error("cse_obs_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] pipe_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
         end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
         end
      end
      assign q = pipe_q[STAGES-1];
   end
endmodule

// File: rtl/cse_verdict_log.sv
module cse_verdict_log #(
   parameter int OUT_W = 3,
   parameter int AW    = 4,
   localparam int CW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cmp_en,
   input  logic [AW-1:0]    idx,
   input  logic [OUT_W-1:0] exp_val,
   input  logic [OUT_W-1:0] obs_val,
   output logic             miss,
   output logic             first_vld,
   output logic [AW-1:0]    first_idx,
   output logic [OUT_W-1:0] first_exp,
   output logic [OUT_W-1:0] first_obs,
   output logic [CW-1:0]    miss_cnt
);
   assign miss = cmp_en && (exp_val != obs_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_vld <= 1'b0;
         first_idx <= '0;
         first_exp <= '0;
         first_obs <= '0;
         miss_cnt  <= '0;
      end else if (clr) begin
         first_vld <= 1'b0;
         first_idx <= '0;
         first_exp <= '0;
         first_obs <= '0;
         miss_cnt  <= '0;
      end else if (miss) begin
         if (!first_vld) begin
            first_vld <= 1'b1;
            first_idx <= idx;
            first_exp <= exp_val;
            first_obs <= obs_val;
         end
         if (miss_cnt != '1) miss_cnt <= miss_cnt + CW'(1);
      end
   end

   // R6
   first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (first_vld && !clr) |=> (first_vld && $stable(first_idx) && $stable(first_exp)
                               && $stable(first_obs)));

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (miss_cnt == $past(miss_cnt) || miss_cnt == $past(miss_cnt) + CW'(1)));
endmodule

// File: rtl/conf_step_exec.sv
module conf_step_exec #(
   parameter int IN_W         = 3,
   parameter int OUT_W        = 3,
   parameter int DEPTH        = 16,
   parameter int SETTLE_W     = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int HALT_ON_FAIL = 0,
   localparam int AW          = $clog2(DEPTH),
   localparam int CW          = AW + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [IN_W-1:0]     wr_stim,
   input  logic [OUT_W-1:0]    wr_expect,
   input  logic [AW-1:0]       last_step,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                start,
   output logic [IN_W-1:0]     dut_in,
   input  logic [OUT_W-1:0]    dut_out,
   output logic                busy,
   output logic                done,
   output logic                run_pass,
   output logic                fail_seen,
   output logic [AW-1:0]       fail_step,
   output logic [OUT_W-1:0]    fail_expect,
   output logic [OUT_W-1:0]    fail_observed,
   output logic [CW-1:0]       mismatch_count
);
   import cse_pkg::*;

   if (IN_W < 1 || OUT_W < 1) begin : g_width_chk
      $error("conf_step_exec: valuation widths must be at least 1");
   end
   if (HALT_ON_FAIL != 0 && HALT_ON_FAIL != 1) begin : g_halt_chk
      $error("conf_step_exec: HALT_ON_FAIL must be 0 or 1");
   end

   phase_t               phase_q;
   logic [AW-1:0]        step_idx;
   logic [AW-1:0]        last_q;
   logic [SETTLE_W-1:0]  settle_q;
   logic [IN_W-1:0]      drive_q;
   logic                 reached_q;
   logic [IN_W-1:0]      rd_stim;
   logic [OUT_W-1:0]     rd_exp;
   logic [OUT_W-1:0]     obs_sync;
   logic                 expired;
   logic                 miss;
   logic                 stop_now;
   logic                 accept;

   assign accept = start && (phase_q == PH_IDLE || phase_q == PH_DONE);

   cse_step_store #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_stim (wr_stim),
      .wr_exp  (wr_expect),
      .rd_addr (step_idx),
      .rd_stim (rd_stim),
      .rd_exp  (rd_exp)
   );

   cse_settle_timer #(.W(SETTLE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_q == PH_APPLY),
      .load_val (settle_q),
      .expired  (expired)
   );

   cse_obs_sync #(.W(OUT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dut_out),
      .q     (obs_sync)
   );

   cse_verdict_log #(.OUT_W(OUT_W), .AW(AW)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .cmp_en    (phase_q == PH_CHECK),
      .idx       (step_idx),
      .exp_val   (rd_exp),
      .obs_val   (obs_sync),
      .miss      (miss),
      .first_vld (fail_seen),
      .first_idx (fail_step),
      .first_exp (fail_expect),
      .first_obs (fail_observed),
      .miss_cnt  (mismatch_count)
   );

   if (HALT_ON_FAIL == 1) begin : g_halt
      assign stop_now = miss;
   end else begin : g_cont
      assign stop_now = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         step_idx  <= '0;
         last_q    <= '0;
         settle_q  <= '0;
         drive_q   <= '0;
         reached_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE, PH_DONE: begin
               if (start) begin
                  settle_q  <= settle_cycles;
                  last_q    <= last_step;
                  step_idx  <= '0;
                  reached_q <= 1'b0;
                  phase_q   <= PH_APPLY;
               end
            end
            PH_APPLY: begin
               drive_q <= rd_stim;
               phase_q <= PH_SETTLE;
            end
            PH_SETTLE: begin
               if (expired) phase_q <= PH_CHECK;
            end
            PH_CHECK: begin
               if (step_idx == last_q) begin
                  reached_q <= 1'b1;
                  phase_q   <= PH_DONE;
               end else if (stop_now) begin
                  phase_q   <= PH_DONE;
               end else begin
                  step_idx  <= step_idx + AW'(1);
                  phase_q   <= PH_APPLY;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign dut_in   = drive_q;
   assign busy     = (phase_q == PH_APPLY) || (phase_q == PH_SETTLE) || (phase_q == PH_CHECK);
   assign done     = (phase_q == PH_DONE);
   assign run_pass = done && reached_q && (mismatch_count == '0);

   // R4
   stim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SETTLE) |=> $stable(dut_in));

   // R7
   pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_pass |-> (done && !fail_seen && mismatch_count == '0));

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !(phase_q == PH_APPLY && step_idx == '0));

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
endmodule

// File: tb/tb_conf_step_exec.sv
module tb_conf_step_exec;
   localparam int IN_W = 3, OUT_W = 3, DEPTH = 16, SW = 8, AW = 4, CW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [IN_W-1:0]   wr_stim = '0;
   logic [OUT_W-1:0]  wr_expect = '0;
   logic [AW-1:0]     last_step = '0;
   logic [SW-1:0]     settle_cycles = '0;
   logic              start = 1'b0;
   logic [IN_W-1:0]   dut_in, h_in;
   logic [OUT_W-1:0]  dut_out;
   logic busy, done, run_pass, fail_seen;
   logic h_busy, h_done, h_pass, h_seen;
   logic [AW-1:0]     fail_step, h_step;
   logic [OUT_W-1:0]  fail_expect, fail_observed, h_exp, h_obs;
   logic [CW-1:0]     mismatch_count, h_cnt;

   conf_step_exec #(.HALT_ON_FAIL(0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_stim(wr_stim),
      .wr_expect(wr_expect), .last_step(last_step), .settle_cycles(settle_cycles),
      .start(start), .dut_in(dut_in), .dut_out(dut_out), .busy(busy), .done(done),
      .run_pass(run_pass), .fail_seen(fail_seen), .fail_step(fail_step),
      .fail_expect(fail_expect), .fail_observed(fail_observed),
      .mismatch_count(mismatch_count));

   conf_step_exec #(.HALT_ON_FAIL(1)) dut_halt (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_stim(wr_stim),
      .wr_expect(wr_expect), .last_step(last_step), .settle_cycles(settle_cycles),
      .start(start), .dut_in(h_in), .dut_out(dut_out), .busy(h_busy), .done(h_done),
      .run_pass(h_pass), .fail_seen(h_seen), .fail_step(h_step),
      .fail_expect(h_exp), .fail_observed(h_obs), .mismatch_count(h_cnt));

   // Device model: Mealy machine that reacts to input changes, output lags two cycles
   function automatic logic [2:0] nxt(logic [2:0] st, logic [2:0] vin);
      return 3'(((int'(st) * 3) + int'(vin) + 1) % 5);
   endfunction
   function automatic logic [2:0] outf(logic [2:0] st, logic [2:0] vin);
      return vin ^ st;
   endfunction

   logic [2:0] d_prev, d_st, d_p0, d_p1;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_prev <= '0; d_st <= '0; d_p0 <= '0; d_p1 <= '0;
      end else begin
         d_prev <= dut_in;
         if (dut_in != d_prev) begin
            d_st <= nxt(d_st, dut_in);
            d_p0 <= outf(d_st, dut_in);
         end
         d_p1 <= d_p0;
      end
   end
   assign dut_out = d_p1;

   int checks = 0;
   int errors = 0;
   logic [2:0] m_st = '0, m_prev = '0, m_out = '0;
   logic [2:0] stim [DEPTH];
   logic [2:0] tru  [DEPTH];
   logic [2:0] wexp [DEPTH];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_run(input int n, input int s, input logic [15:0] fmask, input bit poke);
      int e_cnt = 0;
      int e_first = -1;
      int cyc = 0;
      int halt_cyc = 0;
      int h_steps;
      bit hold_ok = 1'b1;
      bit tmo = 1'b0;
      for (int k = 0; k < n; k++) begin
         stim[k] = 3'($urandom % 8);
         if (stim[k] != m_prev) begin
            m_out = outf(m_st, stim[k]);
            m_st  = nxt(m_st, stim[k]);
         end
         m_prev  = stim[k];
         tru[k]  = m_out;
         wexp[k] = fmask[k] ? (m_out ^ 3'(1 + ($urandom % 7))) : m_out;
         if (fmask[k]) begin
            e_cnt++;
            if (e_first < 0) e_first = k;
         end
      end
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(k); wr_stim = stim[k]; wr_expect = wexp[k];
      end
      @(negedge clk);
      wr_en = 1'b0;
      last_step = AW'(n - 1);
      settle_cycles = SW'(s);
      start = 1'b1;
      forever begin
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         cyc++;
         if (cyc - 1 >= 1) begin
            int k = (cyc - 2) / (s + 3);
            if (k < n && dut_in != stim[k]) hold_ok = 1'b0;
         end
         if (poke && cyc == 4) begin
            start = 1'b1;                       // R9: ignored while busy
            settle_cycles = SW'(s + 5);         // R10: must not alter this run
            last_step = '0;
         end
         if (h_done && halt_cyc == 0) halt_cyc = cyc;
         if (done) break;
         if (cyc > 5000) begin tmo = 1'b1; break; end
      end
      check(!tmo, "R3 run timeout", cyc, n * (s + 3) + 1);
      check(cyc == n * (s + 3) + 1, poke ? "R3/R9/R10 run length" : "R3 run length",
            cyc, n * (s + 3) + 1);
      check(hold_ok, "R2/R4 stimulus per step", 0, 1);
      check(int'(mismatch_count) == e_cnt, "R5 mismatch count", int'(mismatch_count), e_cnt);
      check(run_pass == (e_cnt == 0), "R7 verdict", int'(run_pass), int'(e_cnt == 0));
      check(fail_seen == (e_cnt != 0), "R6 fail seen", int'(fail_seen), int'(e_cnt != 0));
      if (e_cnt != 0) begin
         check(int'(fail_step) == e_first, "R6 first step", int'(fail_step), e_first);
         check(fail_expect == wexp[e_first], "R6 first expect", int'(fail_expect),
               int'(wexp[e_first]));
         check(fail_observed == tru[e_first], "R6 first observed", int'(fail_observed),
               int'(tru[e_first]));
         check(int'(h_step) == e_first, "R8 halt first step", int'(h_step), e_first);
      end
      h_steps = (e_cnt != 0) ? e_first + 1 : n;
      check(halt_cyc == h_steps * (s + 3) + 1, "R8 halt run length", halt_cyc,
            h_steps * (s + 3) + 1);
      check(h_pass == (e_cnt == 0), "R8 halt verdict", int'(h_pass), int'(e_cnt == 0));
      check(int'(h_cnt) == (e_cnt != 0 ? 1 : 0), "R8 halt count", int'(h_cnt),
            e_cnt != 0 ? 1 : 0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(dut_in == '0 && !busy && !done, "R1 reset drive/status", int'(dut_in), 0);
      check(!run_pass && !fail_seen && mismatch_count == '0, "R1 reset verdict",
            int'(mismatch_count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      do_run(1, 4, 16'h0000, 1'b0);             // single step
      do_run(16, 5, 16'h8001, 1'b0);            // first and last step fail
      do_run(16, 4, 16'h8000, 1'b0);            // only last step fails
      do_run(8, 6, 16'h0000, 1'b1);             // R9/R10 poke during run
      for (int r = 0; r < 8; r++) begin
         int n = 1 + ($urandom % 16);
         int s = 4 + ($urandom % 9);
         logic [15:0] fm = 16'($urandom) & 16'($urandom);
         do_run(n, s, fm, r[0]);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule